// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with one shared data bus. It is built so that reads and writes can be issued on every clock in any order, with no idle cycles between them. Every control, address and write-data input is captured on the rising edge of the clock. Read data leaves through an output register. Write data trails its command by the same distance that read data does, so a write can follow a read, or a read a write, with no dead cycle on the bus. The data driver is turned off by itself during each write data phase.

Each word is 36 bits wide, made of four 9-bit lanes (32 data bits plus 4 parity bits). The model's address width is a parameter: the full-size part uses 17 bits, and the default is kept small so that the model stays light in simulation. A clock enable freezes the whole pipeline. A three-input chip select chooses between an access and a deselect. Active-low lane masks control partial writes. An advance input steps a 2-bit burst counter through either linear or interleaved order, instead of taking a new address. Tri-state is not modelled: the block gives a data word together with a separate drive-enable output.

Top module: `psram_top`

## Requirements
- R1: A read captured at enabled edge k puts the word on `q_out`, with `q_drive` high, after enabled edge k+1. The word stays there until the next enabled edge, so the bus owner samples it at edge k+2.
- R2: A write captured at enabled edge k takes its data from `d_in` at enabled edge k+2 and stores it at the address captured at edge k.
- R3: Lane i is bits [9i+8:9i]. A write changes lane i only when `lane_wr_n[i]` is 0. Lanes whose mask bit is 1 keep their old contents.
- R4: Reads and writes may be issued back to back on every cycle. A read always returns the newest byte-merged contents, including those of a write issued one cycle earlier whose data has not yet reached the array.
- R5: While `clk_en` is 0, no command is taken, nothing is written, and `q_out` and `q_drive` hold their values.
- R6: A load cycle (`advance`=0) is an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination is a deselect: it writes nothing and drives nothing.
- R7: `q_drive` is low in the cycle in which a write's data is expected on the bus, and low in every cycle that has no read data.
- R8: `oe_n`=1 forces `q_drive` low at once, without waiting for a clock edge.
- R9: An advance cycle (`advance`=1) continues the live burst with the same read/write type. It changes only address bits [1:0] and ignores `wr_n`, the chip selects and `addr`.
- R10: With `burst_ilv`=0, beat n of a burst starting at low bits s uses low bits (s+n) mod 4.
- R11: With `burst_ilv`=1, beat n uses low bits s XOR n.
- R12: An advance cycle when no burst is live (after reset or after a deselect load) is a deselect.
- R13: While `rst` is high, the pipeline empties and `q_drive` is low after the next edge. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline and burst state |
| clk_en | input | 1 | 1 lets the pipeline move; 0 freezes it |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read on a load cycle |
| lane_wr_n | input | 4 | Per-lane write mask, active low |
| advance | input | 1 | 1 = step the burst counter, 0 = load `addr` |
| burst_ilv | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr | input | AW | Word address for load cycles |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 36 | Write data, sampled two enabled edges after its command |
| q_out | output | 36 | Registered read data |
| q_drive | output | 1 | High when the block should drive the bus with `q_out` |

## Verification
The assertions assume that `rst` is high at time zero and stays high for at least one edge. They also assume that `burst_ilv` changes only while no burst is live, so the burst checks can compare each beat with the one before it. The stimulus keeps to both conditions: it starts in reset and changes the order select only after a deselect load. The advance cycles drive random values on the chip selects, `wr_n` and `addr` to show that these inputs are ignored there. The array is filled completely before its first read, so no unwritten word is ever compared.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Low address bits for one beat of a burst.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    beat_low = ilv ? (start ^ beat) : (start + beat);
  endfunction

  // Overlay the lanes whose active-low mask bit is 0.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  keep_n);
    lane_merge = old_w;
    for (int i = 0; i < LANES; i++)
      if (!keep_n[i]) lane_merge[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
  endfunction
endpackage

// File: rtl/psram_burst.sv
module psram_burst #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          advance,
  input  logic          selected,
  input  logic          wr_req,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output logic          cmd_vld,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr,
  output logic          live
);
  import psram_pkg::*;

  logic          live_wr;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nxt;

  assign cnt_nxt = cnt + 2'd1;

  always_comb begin
    if (advance) begin
      cmd_vld  = live;
      cmd_wr   = live_wr;
      cmd_addr = {base[AW-1:2], beat_low(base[1:0], cnt_nxt, ilv)};
    end else begin
      cmd_vld  = selected;
      cmd_wr   = wr_req;
      cmd_addr = addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      live_wr <= 1'b0;
      base    <= '0;
      cnt     <= '0;
    end else if (en) begin
      if (!advance) begin
        live    <= selected;
        live_wr <= wr_req;
        base    <= addr;
        cnt     <= '0;
      end else if (live) begin
        cnt <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/psram_pipe.sv
module psram_pipe #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_vld,
  input  logic             in_wr,
  input  logic [AW-1:0]    in_addr,
  input  logic [LANES-1:0] in_lane_n,
  output logic             rd_vld,
  output logic             rd_wr,
  output logic [AW-1:0]    rd_addr,
  output logic             wb_vld,
  output logic             wb_wr,
  output logic [AW-1:0]    wb_addr,
  output logic [LANES-1:0] wb_lane_n
);
  localparam int LAST = STAGES - 1;

  logic             v [STAGES];
  logic             w [STAGES];
  logic [AW-1:0]    a [STAGES];
  logic [LANES-1:0] l [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v[g] <= 1'b0;
        else if (en) begin
          v[g] <= in_vld;
          w[g] <= in_wr;
          a[g] <= in_addr;
          l[g] <= in_lane_n;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) v[g] <= 1'b0;
        else if (en) begin
          v[g] <= v[g-1];
          w[g] <= w[g-1];
          a[g] <= a[g-1];
          l[g] <= l[g-1];
        end
      end
    end
  end

  assign rd_vld    = v[0];
  assign rd_wr     = w[0];
  assign rd_addr   = a[0];
  assign wb_vld    = v[LAST];
  assign wb_wr     = w[LAST];
  assign wb_addr   = a[LAST];
  assign wb_lane_n = l[LAST];

  // R2: each command reaches the write-back stage one enabled edge later
  assert_stage_advance_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (wb_vld == $past(v[LAST-1])));
endmodule

// File: rtl/psram_store.sv
module psram_store #(
  parameter int AW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         rd_vld,
  input  logic                         rd_wr,
  input  logic [AW-1:0]                rd_addr,
  input  logic                         wb_vld,
  input  logic                         wb_wr,
  input  logic [AW-1:0]                wb_addr,
  input  logic [psram_pkg::LANES-1:0]  wb_lane_n,
  input  logic [psram_pkg::WORD_W-1:0] d_in,
  output logic [psram_pkg::WORD_W-1:0] q_reg,
  output logic                         q_vld
);
  import psram_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wb_fire;
  logic              rd_fire;
  logic              fwd_hit;
  logic [WORD_W-1:0] rd_raw;
  logic [WORD_W-1:0] rd_word;

  assign wb_fire = en && wb_vld && wb_wr;
  assign rd_fire = rd_vld && !rd_wr;
  assign fwd_hit = wb_vld && wb_wr && (wb_addr == rd_addr);
  assign rd_raw  = mem[rd_addr];
  assign rd_word = fwd_hit ? lane_merge(rd_raw, d_in, wb_lane_n) : rd_raw;

  always_ff @(posedge clk) begin
    if (wb_fire) mem[wb_addr] <= lane_merge(mem[wb_addr], d_in, wb_lane_n);
  end

  always_ff @(posedge clk) begin
    if (rst) q_vld <= 1'b0;
    else if (en) begin
      q_vld <= rd_fire;
      if (rd_fire) q_reg <= rd_word;
    end
  end

  // R5: a frozen clock leaves the output register untouched
  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q_vld) && $stable(q_reg)));
  // R7: a write entering the read stage releases the bus for its data phase
  assert_release_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    (en && rd_vld && rd_wr) |=> !q_vld);
  // R13: reset empties the output stage
  assert_reset_idle_R13: assert property (@(posedge clk)
    rst |=> !q_vld);
endmodule

// File: rtl/psram_top.sv
module psram_top #(
  parameter int AW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clk_en,
  input  logic                         sel0_n,
  input  logic                         sel1,
  input  logic                         sel2_n,
  input  logic                         wr_n,
  input  logic [psram_pkg::LANES-1:0]  lane_wr_n,
  input  logic                         advance,
  input  logic                         burst_ilv,
  input  logic [AW-1:0]                addr,
  input  logic                         oe_n,
  input  logic [psram_pkg::WORD_W-1:0] d_in,
  output logic [psram_pkg::WORD_W-1:0] q_out,
  output logic                         q_drive
);
  import psram_pkg::*;

  logic             selected;
  logic             cmd_vld, cmd_wr, live;
  logic [AW-1:0]    cmd_addr;
  logic             rd_vld, rd_wr, wb_vld, wb_wr;
  logic [AW-1:0]    rd_addr, wb_addr;
  logic [LANES-1:0] wb_lane_n;
  logic             q_vld;

  assign selected = !sel0_n && sel1 && !sel2_n;

  psram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .en(clk_en), .advance(advance), .selected(selected),
    .wr_req(!wr_n), .ilv(burst_ilv), .addr(addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .live(live)
  );

  psram_pipe #(.AW(AW), .LANES(LANES), .STAGES(2)) u_pipe (
    .clk(clk), .rst(rst), .en(clk_en),
    .in_vld(cmd_vld), .in_wr(cmd_wr), .in_addr(cmd_addr), .in_lane_n(lane_wr_n),
    .rd_vld(rd_vld), .rd_wr(rd_wr), .rd_addr(rd_addr),
    .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_addr(wb_addr), .wb_lane_n(wb_lane_n)
  );

  psram_store #(.AW(AW)) u_store (
    .clk(clk), .rst(rst), .en(clk_en),
    .rd_vld(rd_vld), .rd_wr(rd_wr), .rd_addr(rd_addr),
    .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_addr(wb_addr), .wb_lane_n(wb_lane_n),
    .d_in(d_in), .q_reg(q_out), .q_vld(q_vld)
  );

  assign q_drive = q_vld && !oe_n;

  // R6: an unselected load cycle enters the pipeline as an empty slot
  assert_deselect_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !advance && !selected) |=> !rd_vld);
  // R12: advancing with no live burst is a deselect
  assert_dead_advance_R12: assert property (@(posedge clk) disable iff (rst)
    (clk_en && advance && !live) |=> !rd_vld);
  // R9: burst beats stay in the same four-word group and keep the type
  assert_burst_row_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && advance && live) |=>
      (rd_addr[AW-1:2] == $past(rd_addr[AW-1:2]) && rd_wr == $past(rd_wr)));
  // R10: linear order steps the low bits by one per beat
  assert_linear_step_R10: assert property (@(posedge clk) disable iff (rst)
    (clk_en && advance && live && !burst_ilv) |=>
      (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1));
endmodule

// File: tb/psram_top_test.sv
module psram_top_test;
  localparam int AW = 6;
  localparam int WW = 36;
  localparam int N  = 1 << AW;
  localparam logic [2:0] SEL = 3'b010;  // {sel0_n, sel1, sel2_n}

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic          rst = 1, clk_en = 0, sel0_n = 1, sel1 = 0, sel2_n = 1, wr_n = 1;
  logic [3:0]    lane_wr_n = 4'hF;
  logic          advance = 0, burst_ilv = 0, oe_n = 0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] d_in = '0;
  logic [WW-1:0] q_out;
  logic          q_drive;

  psram_top #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .advance(advance), .burst_ilv(burst_ilv),
    .addr(addr), .oe_n(oe_n), .d_in(d_in), .q_out(q_out), .q_drive(q_drive)
  );

  int checks = 0, fails = 0;

  // reference state
  logic [WW-1:0] ref_mem [N];
  logic          m_live = 0, m_lwr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [AW-1:0] p1a = '0, p2a = '0;
  logic [3:0]    p1l = 4'hF, p2l = 4'hF;
  logic [WW-1:0] p1d = '0, p2d = '0;
  logic          exp_v = 0;
  logic [WW-1:0] exp_q = '0;

  function automatic logic [WW-1:0] pat(input int a, input int salt);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1 ^ (32'(salt) << 20) ^ 32'h1357_2468;
    return {4'(salt + a), h};
  endfunction

  function automatic logic [WW-1:0] mix(input logic [WW-1:0] o, input logic [WW-1:0] n,
                                        input logic [3:0] m);
    logic [WW-1:0] r = o;
    for (int k = 0; k < 4; k++) if (m[k] == 1'b0) r[9*k +: 9] = n[9*k +: 9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                     input logic [WW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at the next negedge.
  task automatic step(input bit en, input bit adv, input logic [2:0] s, input bit wn,
                      input logic [3:0] ln, input int a, input logic [WW-1:0] wd,
                      input bit oe, input string tag);
    bit c_v, c_w;
    logic [AW-1:0] c_a;
    bit drv;
    clk_en = en; advance = adv; {sel0_n, sel1, sel2_n} = s; wr_n = wn;
    lane_wr_n = ln; addr = AW'(a); oe_n = oe;
    d_in = (p2v && p2w) ? p2d : 36'hA_5A5A_5A5A;
    if (adv) begin
      c_v = m_live; c_w = m_lwr;
      c_a = {m_base[AW-1:2], (burst_ilv ? (m_base[1:0] ^ (m_cnt + 2'd1))
                                        : (m_base[1:0] + m_cnt + 2'd1))};
    end else begin
      c_v = (s == SEL); c_w = !wn; c_a = AW'(a);
    end
    @(posedge clk);
    if (en) begin
      if (p2v && p2w) ref_mem[p2a] = mix(ref_mem[p2a], p2d, p2l);
      exp_v = p1v && !p1w;
      if (exp_v) exp_q = ref_mem[p1a];
      if (!adv) begin m_live = (s == SEL); m_lwr = !wn; m_base = AW'(a); m_cnt = 0; end
      else if (m_live) m_cnt = m_cnt + 2'd1;
      p2v = p1v; p2w = p1w; p2a = p1a; p2l = p1l; p2d = p1d;
      p1v = c_v; p1w = c_w; p1a = c_a; p1l = ln; p1d = wd;
    end
    @(negedge clk);
    drv = exp_v && !oe;
    chk(q_drive == drv, {tag, " drive"}, {35'b0, q_drive}, {35'b0, drv});
    if (drv) chk(q_out == exp_q, {tag, " data"}, q_out, exp_q);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 3'b000, 1, 4'hF, 0, '0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_drive == 1'b0, "R13 reset", {35'b0, q_drive}, '0);
    rst = 0;

    // R2: fill every word, back to back
    for (int a = 0; a < N; a++) step(1, 0, SEL, 0, 4'h0, a, pat(a, 1), 0, "R2");
    idle(2, "R7");
    // R1: read every word back to back
    for (int a = 0; a < N; a++) step(1, 0, SEL, 1, 4'h0, a, '0, 0, "R1");
    idle(2, "R1");

    // R3/R4: every lane mask, read issued right after its write
    for (int m = 0; m < 16; m++) begin
      step(1, 0, SEL, 0, 4'(m), m, pat(m, 2), 0, "R3");
      step(1, 0, SEL, 1, 4'h0, m, '0, 0, "R4");
    end
    for (int m = 0; m < 16; m++) step(1, 0, SEL, 1, 4'h0, m, '0, 0, "R3");
    idle(2, "R3");

    // R7: read and write to neighbours alternate every cycle
    for (int k = 0; k < 12; k++) step(1, 0, SEL, k[0], 4'h0, 30 + k[1], pat(k, 4), 0, "R7");
    idle(2, "R7");

    // R6: all chip select combinations on a write
    for (int s = 0; s < 8; s++) begin
      step(1, 0, 3'(s), 0, 4'h0, 40, pat(s, 3), 0, "R6");
      idle(1, "R6");
      step(1, 0, SEL, 1, 4'h0, 40, '0, 0, "R6");
      idle(2, "R6");
    end

    // R9/R10/R11: write then read bursts at every start, both orders
    for (int o = 0; o < 2; o++) begin
      burst_ilv = o[0];
      for (int st = 0; st < 4; st++) begin
        step(1, 0, SEL, 0, 4'h0, 16 + st, pat(st, 10 + o), 0, o ? "R11" : "R10");
        for (int b = 1; b < 4; b++)
          step(1, 1, 3'(b * 3), b[0], 4'h0, 7 * b, pat(st * 4 + b, 10 + o), 0, "R9");
        step(1, 0, SEL, 1, 4'h0, 16 + st, '0, 0, o ? "R11" : "R10");
        for (int b = 1; b < 4; b++) step(1, 1, 3'(b), 0, 4'h0, 5 * b, '0, 0, "R9");
        for (int w = 16; w < 20; w++) step(1, 0, SEL, 1, 4'h0, w, '0, 0, o ? "R11" : "R10");
        idle(2, "R9");
      end
    end
    burst_ilv = 0;

    // R5: stalled cycles carry a write to word 60 that must not land
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 0) step(0, 0, SEL, 0, 4'h0, 60, pat(k, 6), 0, "R5");
      else step(1, 0, SEL, k[0], 4'h0, 50 + k % 4, pat(k, 7), 0, "R5");
    end
    idle(2, "R5");
    step(1, 0, SEL, 1, 4'h0, 60, '0, 0, "R5");
    step(0, 0, SEL, 0, 4'h0, 61, pat(1, 8), 0, "R5");
    step(0, 0, SEL, 0, 4'h0, 61, pat(2, 8), 0, "R5");
    idle(2, "R5");

    // R12: advance after a deselect load writes nothing
    step(1, 0, 3'b000, 0, 4'h0, 20, '0, 0, "R12");
    step(1, 1, SEL, 0, 4'h0, 21, pat(1, 9), 0, "R12");
    step(1, 1, SEL, 0, 4'h0, 22, pat(2, 9), 0, "R12");
    idle(2, "R12");
    for (int w = 20; w < 24; w++) step(1, 0, SEL, 1, 4'h0, w, '0, 0, "R12");
    idle(2, "R12");

    // R8: output enable masks read data
    for (int k = 0; k < 8; k++) step(1, 0, SEL, 1, 4'h0, k, '0, k[0], "R8");
    idle(2, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule